// File: doc/BRIEF.md
# Unaligned Partial-Word Load/Store Merger

This block is the byte-lane splicing datapath that lets a processor reach an unaligned word or doubleword through two aligned memory accesses. For a left or right partial load it combines a shifted copy of the aligned memory word with the bytes of the old register value that must survive. For a left or right partial store it combines the register bytes with the memory bytes that must survive, and it produces a byte-enable mask for the memory write.

An operation code, the low effective-address bits, an endianness mode, the aligned memory word and the old register value are presented together with `in_valid`. One cycle later the block presents the merged register value (loads) or the merged memory word with byte enables (stores), qualified by `out_valid`. A parameter decides whether the eight-byte forms are built. When they are not, an eight-byte op code is flagged as illegal.

Top module: `ulm_merge_top`

## Requirements
- R1: The splice position k is taken from the low address bits. For four-byte ops k is addr[1:0] when `big_endian` is 1 and addr[1:0] XOR 3 when it is 0. For eight-byte ops k is addr[2:0] when `big_endian` is 1 and addr[2:0] XOR 7 when it is 0.
- R2: Load-left, four bytes (op 3'b000): the result is the memory word moved up by 8·k bits, and its low k bytes come from the old register.
- R3: Load-right, four bytes (op 3'b001): the result is the memory word moved down by 8·(3−k) bits, and its upper 3−k bytes come from the old register.
- R4: Store-left, four bytes (op 3'b010): the top k bytes of the memory word are kept, and the remaining bytes are the register moved down by 8·k bits.
- R5: Store-right, four bytes (op 3'b011): the low 3−k bytes of the memory word are kept, and the remaining bytes are the register moved up by 8·(3−k) bits.
- R6: Four-byte ops use only bits 31:0 of `mem_rdata` and `reg_val`. Their load results are sign-extended from bit 31 to 64 bits. Their store data has bits 63:32 at zero and `store_be[7:4]` at zero.
- R7: The eight-byte forms follow R2–R5 over eight byte positions with shifts up to 56 bits: load-left 3'b100, load-right 3'b101, store-left 3'b110, store-right 3'b111.
- R8: For stores, `store_be[i]` is 1 exactly for the memory bytes taken from the register, and `load_result` is zero. For loads, `store_data` and `store_be` are zero.
- R9: The outputs and `out_valid` appear on the clock edge after the one that samples `in_valid` high. `out_valid` is 0 after a cycle without `in_valid`. Synchronous reset clears `out_valid`, `illegal_op` and all data outputs to zero.
- R10: With `ENABLE_DWORD` = 0, an accepted op with op[2] = 1 sets `out_valid` and `illegal_op` and leaves `load_result`, `store_data` and `store_be` unchanged. The next legal op clears `illegal_op`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs are sampled when high |
| op | input | 3 | bit2 = eight-byte, bit1 = store, bit0 = right form |
| addr_lo | input | 3 | Low effective-address bits |
| big_endian | input | 1 | 1 = big-endian byte numbering |
| mem_rdata | input | 64 | Aligned memory word read from memory |
| reg_val | input | 64 | Old register value |
| out_valid | output | 1 | Registered result valid |
| illegal_op | output | 1 | Eight-byte op requested while not built |
| load_result | output | 64 | Merged register value |
| store_data | output | 64 | Merged memory word |
| store_be | output | 8 | Byte enables of register-sourced bytes |

## Verification
On every accepted cycle, the assertions check the following:
- the number of enabled store bytes and of retained register bytes against k;
- sign extension of four-byte load results;
- zero enables after loads;
- `out_valid` following `in_valid`;
- held data while `illegal_op` is up.

Only the bench scenarios can show the byte placement itself for each form, address and endianness, the hand-worked splice values, the reset and mid-run reset state, and the illegal-op behaviour of a build without the eight-byte forms.

// File: rtl/ulm_pkg.sv
package ulm_pkg;
  localparam int BYTE_W      = 8;
  localparam int WORD_BYTES  = 4;
  localparam int DWORD_BYTES = 8;
  localparam int REG_W       = DWORD_BYTES * BYTE_W;
  localparam int WORD_W      = WORD_BYTES * BYTE_W;
  localparam int OP_W        = 3;
  localparam int ADDR_W      = $clog2(DWORD_BYTES);
  localparam int WK_W        = $clog2(WORD_BYTES);
  localparam int DK_W        = $clog2(DWORD_BYTES);
  // op field positions
  localparam int OP_RIGHT_BIT = 0;
  localparam int OP_STORE_BIT = 1;
  localparam int OP_DW_BIT    = 2;

  typedef enum logic [OP_W-1:0] {
    OP_LD_L_W = 3'b000,
    OP_LD_R_W = 3'b001,
    OP_ST_L_W = 3'b010,
    OP_ST_R_W = 3'b011,
    OP_LD_L_D = 3'b100,
    OP_LD_R_D = 3'b101,
    OP_ST_L_D = 3'b110,
    OP_ST_R_D = 3'b111
  } ulm_op_e;
endpackage

// File: rtl/ulm_lane_offset.sv
// Endian-adjusted splice position: big-endian uses the address bits as-is,
// little-endian mirrors them within the access size.
module ulm_lane_offset #(
  parameter int KW = 2
) (
  input  logic [KW-1:0] addr_bits,
  input  logic          big_endian,
  output logic [KW-1:0] k
);
  localparam logic [KW-1:0] MIRROR = {KW{1'b1}};

  always_comb begin
    if (big_endian) k = addr_bits;
    else            k = addr_bits ^ MIRROR;
  end
endmodule

// File: rtl/ulm_merge_unit.sv
// Per-size splice datapath: computes both the load merge and the store merge
// for NB byte positions. Byte selection is driven by per-lane compare masks.
module ulm_merge_unit #(
  parameter int NB = 4,
  parameter int KW = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [KW-1:0]   k,
  input  logic            is_right,
  input  logic [NB*8-1:0] mem,
  input  logic [NB*8-1:0] regv,
  output logic [NB*8-1:0] load_out,
  output logic [NB*8-1:0] store_out,
  output logic [NB-1:0]   be_out
);
  localparam int W = NB * 8;
  localparam logic [KW-1:0] KMAX = KW'(NB - 1);

  logic [KW-1:0] kr;          // mirrored position, NB-1-k
  logic [W-1:0]  ll_sh, lr_sh, sl_sh, sr_sh;
  logic [NB-1:0] ll_keep, lr_take, sl_en, sr_en;
  logic [W-1:0]  ll_keep_b, lr_take_b, sl_en_b, sr_en_b;
  logic [NB-1:0] reg_keep;

  assign kr    = KMAX - k;
  assign ll_sh = mem  << {k,  3'b000};
  assign lr_sh = mem  >> {kr, 3'b000};
  assign sl_sh = regv >> {k,  3'b000};
  assign sr_sh = regv << {kr, 3'b000};

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign ll_keep[i] = (i <  int'(k));
    assign lr_take[i] = (i <= int'(k));
    assign sl_en[i]   = (i <= int'(kr));
    assign sr_en[i]   = (i >= int'(kr));
    assign ll_keep_b[8*i +: 8] = {8{ll_keep[i]}};
    assign lr_take_b[8*i +: 8] = {8{lr_take[i]}};
    assign sl_en_b[8*i +: 8]   = {8{sl_en[i]}};
    assign sr_en_b[8*i +: 8]   = {8{sr_en[i]}};
  end

  always_comb begin
    if (is_right) begin
      load_out  = (lr_sh & lr_take_b) | (regv & ~lr_take_b);
      store_out = (sr_sh & sr_en_b)   | (mem  & ~sr_en_b);
      be_out    = sr_en;
      reg_keep  = ~lr_take;
    end else begin
      load_out  = (ll_sh & ~ll_keep_b) | (regv & ll_keep_b);
      store_out = (sl_sh & sl_en_b)    | (mem  & ~sl_en_b);
      be_out    = sl_en;
      reg_keep  = ll_keep;
    end
  end

  // R8: enabled store bytes number k+1 (right) or NB-k (left)
  a_r8_be_count: assert property (@(posedge clk) disable iff (rst)
    en |-> ($countones(be_out) == (is_right ? int'(k) + 1 : NB - int'(k))));

  // R2/R3: retained register bytes number k (left) or NB-1-k (right)
  a_r3_reg_keep_count: assert property (@(posedge clk) disable iff (rst)
    en |-> ($countones(reg_keep) == (is_right ? NB - 1 - int'(k) : int'(k))));
endmodule

// File: rtl/ulm_merge_top.sv
module ulm_merge_top #(
  parameter bit ENABLE_DWORD = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [2:0]  op,
  input  logic [2:0]  addr_lo,
  input  logic        big_endian,
  input  logic [63:0] mem_rdata,
  input  logic [63:0] reg_val,
  output logic        out_valid,
  output logic        illegal_op,
  output logic [63:0] load_result,
  output logic [63:0] store_data,
  output logic [7:0]  store_be
);
  import ulm_pkg::*;

  logic [WK_W-1:0] k_w;
  logic [DK_W-1:0] k_d;
  logic [WORD_W-1:0] w_load, w_store;
  logic [WORD_BYTES-1:0] w_be;
  logic [REG_W-1:0] d_load, d_store;
  logic [DWORD_BYTES-1:0] d_be;

  logic is_dw, is_store, is_right, bad_op;
  logic [REG_W-1:0] load_full, store_full;
  logic [DWORD_BYTES-1:0] be_full;

  assign is_right = op[OP_RIGHT_BIT];
  assign is_store = op[OP_STORE_BIT];
  assign is_dw    = op[OP_DW_BIT] & ENABLE_DWORD;
  assign bad_op   = op[OP_DW_BIT] & ~ENABLE_DWORD;

  ulm_lane_offset #(.KW(WK_W)) u_off_w (
    .addr_bits (addr_lo[WK_W-1:0]),
    .big_endian(big_endian),
    .k         (k_w)
  );

  ulm_merge_unit #(.NB(WORD_BYTES)) u_merge_w (
    .clk      (clk),
    .rst      (rst),
    .en       (in_valid & ~op[OP_DW_BIT]),
    .k        (k_w),
    .is_right (is_right),
    .mem      (mem_rdata[WORD_W-1:0]),
    .regv     (reg_val[WORD_W-1:0]),
    .load_out (w_load),
    .store_out(w_store),
    .be_out   (w_be)
  );

  if (ENABLE_DWORD) begin : g_dw
    ulm_lane_offset #(.KW(DK_W)) u_off_d (
      .addr_bits (addr_lo[DK_W-1:0]),
      .big_endian(big_endian),
      .k         (k_d)
    );

    ulm_merge_unit #(.NB(DWORD_BYTES)) u_merge_d (
      .clk      (clk),
      .rst      (rst),
      .en       (in_valid & op[OP_DW_BIT]),
      .k        (k_d),
      .is_right (is_right),
      .mem      (mem_rdata),
      .regv     (reg_val),
      .load_out (d_load),
      .store_out(d_store),
      .be_out   (d_be)
    );
  end else begin : g_no_dw
    assign k_d     = '0;
    assign d_load  = '0;
    assign d_store = '0;
    assign d_be    = '0;
  end

  always_comb begin
    if (is_dw) begin
      load_full  = d_load;
      store_full = d_store;
      be_full    = d_be;
    end else begin
      load_full  = {{(REG_W-WORD_W){w_load[WORD_W-1]}}, w_load};
      store_full = {{(REG_W-WORD_W){1'b0}}, w_store};
      be_full    = {{(DWORD_BYTES-WORD_BYTES){1'b0}}, w_be};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      illegal_op  <= 1'b0;
      load_result <= '0;
      store_data  <= '0;
      store_be    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        illegal_op <= bad_op;
        if (!bad_op) begin
          if (is_store) begin
            load_result <= '0;
            store_data  <= store_full;
            store_be    <= be_full;
          end else begin
            load_result <= load_full;
            store_data  <= '0;
            store_be    <= '0;
          end
        end
      end
    end
  end

  // R9: a result only appears after an accepted input
  a_r9_valid_follows_input: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R10: illegal flag only for eight-byte ops in a build without them
  a_r10_flag_cause: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal_op) |-> (!ENABLE_DWORD && $past(op[OP_DW_BIT])));

  // R10: data outputs hold across an illegal op
  a_r10_hold_data: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal_op) |->
      ($stable(load_result) && $stable(store_data) && $stable(store_be)));

  // R8: loads never raise byte enables
  a_r8_load_no_be: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !illegal_op && !$past(op[OP_STORE_BIT])) |->
      (store_be == '0 && store_data == '0));

  // R6: four-byte loads are sign-extended from bit 31
  a_r6_sign_ext: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !illegal_op && $past(op[OP_DW_BIT:OP_STORE_BIT]) == 2'b00) |->
      (load_result[63:32] == {32{load_result[31]}}));
endmodule

// File: tb/ulm_merge_top_tb_top.sv
module ulm_merge_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [2:0] op = 3'd0;
  logic [2:0] addr_lo = 3'd0;
  logic big_endian = 1'b1;
  logic [63:0] mem_rdata = '0;
  logic [63:0] reg_val = '0;

  logic out_valid, illegal_op;
  logic [63:0] load_result, store_data;
  logic [7:0] store_be;
  logic nd_valid, nd_illegal;
  logic [63:0] nd_load, nd_store;
  logic [7:0] nd_be;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  ulm_merge_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .addr_lo(addr_lo),
    .big_endian(big_endian), .mem_rdata(mem_rdata), .reg_val(reg_val),
    .out_valid(out_valid), .illegal_op(illegal_op), .load_result(load_result),
    .store_data(store_data), .store_be(store_be)
  );

  ulm_merge_top #(.ENABLE_DWORD(1'b0)) dut_nodw_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .addr_lo(addr_lo),
    .big_endian(big_endian), .mem_rdata(mem_rdata), .reg_val(reg_val),
    .out_valid(nd_valid), .illegal_op(nd_illegal), .load_result(nd_load),
    .store_data(nd_store), .store_be(nd_be)
  );

  // op, addr, big_endian, memory word, register
  localparam int NV = 16;
  localparam logic [134:0] VECS [NV] = '{
    {3'b000, 3'd0, 1'b1, 64'hDEAD_BEEF_8091_A2B3, 64'h0F1E_2D3C_4B5A_6978},
    {3'b000, 3'd2, 1'b0, 64'h1111_2222_7F00_1234, 64'hAAAA_BBBB_CCDD_EEFF},
    {3'b001, 3'd1, 1'b1, 64'h0000_0000_C001_D00D, 64'h1234_5678_9ABC_DEF0},
    {3'b001, 3'd3, 1'b0, 64'hFFFF_0000_4455_6677, 64'h8899_AABB_CCDD_EEFF},
    {3'b010, 3'd3, 1'b1, 64'h5555_5555_A0B0_C0D0, 64'h0102_0304_0506_0708},
    {3'b010, 3'd1, 1'b0, 64'h0000_0000_1020_3040, 64'hFEDC_BA98_7654_3210},
    {3'b011, 3'd2, 1'b1, 64'h9999_9999_0A0B_0C0D, 64'h0000_0000_E1E2_E3E4},
    {3'b011, 3'd0, 1'b0, 64'h0000_0000_F0F1_F2F3, 64'h7777_7777_1357_9BDF},
    {3'b100, 3'd3, 1'b1, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210},
    {3'b100, 3'd7, 1'b0, 64'h8877_6655_4433_2211, 64'h0102_0304_0506_0708},
    {3'b101, 3'd4, 1'b1, 64'hA1A2_A3A4_A5A6_A7A8, 64'h1112_1314_1516_1718},
    {3'b101, 3'd6, 1'b0, 64'hC3C2_C1C0_B3B2_B1B0, 64'h0000_1111_2222_3333},
    {3'b110, 3'd5, 1'b1, 64'h0F0E_0D0C_0B0A_0908, 64'hF1F2_F3F4_F5F6_F7F8},
    {3'b110, 3'd2, 1'b0, 64'h1357_9BDF_2468_ACE0, 64'hDEAD_BEEF_CAFE_F00D},
    {3'b111, 3'd1, 1'b1, 64'h4444_3333_2222_1111, 64'h89AB_CDEF_0123_4567},
    {3'b111, 3'd7, 1'b0, 64'h6060_5050_4040_3030, 64'h0A0B_0C0D_0E0F_0102}
  };

  // Independent byte-indexed model of R1-R8
  function automatic void model(input logic [2:0] mop, input logic [2:0] a,
                                input logic be_mode, input logic [63:0] mem,
                                input logic [63:0] rv, output logic [63:0] res,
                                output logic [63:0] sd, output logic [7:0] be);
    int n, k, m;
    n = mop[2] ? 8 : 4;
    m = n - 1;
    k = be_mode ? (int'(a) % n) : ((int'(a) % n) ^ m);
    res = '0; sd = '0; be = '0;
    for (int i = 0; i < n; i++) begin
      case (mop[1:0])
        2'b00: res[8*i +: 8] = (i >= k) ? mem[8*(i-k) +: 8] : rv[8*i +: 8];
        2'b01: res[8*i +: 8] = (i <= k) ? mem[8*(i+m-k) +: 8] : rv[8*i +: 8];
        2'b10: begin
          if (i <= m - k) begin sd[8*i +: 8] = rv[8*(i+k) +: 8]; be[i] = 1'b1; end
          else sd[8*i +: 8] = mem[8*i +: 8];
        end
        default: begin
          if (i >= m - k) begin sd[8*i +: 8] = rv[8*(i-(m-k)) +: 8]; be[i] = 1'b1; end
          else sd[8*i +: 8] = mem[8*i +: 8];
        end
      endcase
    end
    if (!mop[1] && !mop[2]) res[63:32] = {32{res[31]}};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [2:0] a, input logic b,
                       input logic [63:0] m, input logic [63:0] r);
    @(negedge clk);
    op = o; addr_lo = a; big_endian = b; mem_rdata = m; reg_val = r;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL R9 watchdog actual=%0d expected<=100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] e_res, e_sd;
    logic [7:0]  e_be;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R9 reset illegal", {63'd0, illegal_op}, 64'd0);
    chk("R9 reset load_result", load_result, 64'd0);
    chk("R9 reset store_be", {56'd0, store_be}, 64'd0);
    rst = 1'b0;

    // Table walk: R1-R8 across all forms, addresses and endianness
    for (int v = 0; v < NV; v++) begin
      apply(VECS[v][134:132], VECS[v][131:129], VECS[v][128],
            VECS[v][127:64], VECS[v][63:0]);
      model(VECS[v][134:132], VECS[v][131:129], VECS[v][128],
            VECS[v][127:64], VECS[v][63:0], e_res, e_sd, e_be);
      chk($sformatf("R7 R8 vec%0d load_result", v), load_result, e_res);
      chk($sformatf("R7 R8 vec%0d store_data", v), store_data, e_sd);
      chk($sformatf("R8 vec%0d store_be", v), {56'd0, store_be}, {56'd0, e_be});
      chk($sformatf("R9 vec%0d out_valid", v), {63'd0, out_valid}, 64'd1);
    end

    // R9: no input -> out_valid low
    @(negedge clk);
    chk("R9 idle out_valid", {63'd0, out_valid}, 64'd0);

    // Hand-worked splices
    apply(3'b000, 3'd1, 1'b1, 64'h7777_7777_A1B2_C3D4, 64'h1122_3344_5566_7788);
    chk("R2 R6 load-left BE k1", load_result, 64'hFFFF_FFFF_B2C3_D488);
    chk("R10 nodw word op legal", {63'd0, nd_illegal}, 64'd0);
    chk("R2 nodw word result", nd_load, 64'hFFFF_FFFF_B2C3_D488);

    // R10: eight-byte op in build without it
    apply(3'b100, 3'd5, 1'b0, 64'h0123_4567_89AB_CDEF, 64'h1122_3344_5566_7788);
    chk("R1 R7 load-left LE dword k2", load_result, 64'h4567_89AB_CDEF_7788);
    chk("R10 nodw illegal set", {63'd0, nd_illegal}, 64'd1);
    chk("R10 nodw out_valid", {63'd0, nd_valid}, 64'd1);
    chk("R10 nodw data held", nd_load, 64'hFFFF_FFFF_B2C3_D488);
    chk("R10 main build legal", {63'd0, illegal_op}, 64'd0);

    apply(3'b001, 3'd2, 1'b1, 64'h0000_0000_A1B2_C3D4, 64'h1122_3344_5566_7788);
    chk("R3 load-right BE k2", load_result, 64'h0000_0000_55A1_B2C3);
    chk("R10 nodw illegal cleared", {63'd0, nd_illegal}, 64'd0);

    apply(3'b010, 3'd0, 1'b0, 64'hFFFF_FFFF_A1B2_C3D4, 64'h1122_3344_5566_7788);
    chk("R1 R4 store-left LE k3 data", store_data, 64'h0000_0000_A1B2_C355);
    chk("R4 store-left be", {56'd0, store_be}, 64'h01);
    chk("R8 store load_result zero", load_result, 64'd0);

    apply(3'b011, 3'd0, 1'b1, 64'h0000_0000_A1B2_C3D4, 64'h1122_3344_5566_7788);
    chk("R5 store-right BE k0 data", store_data, 64'h0000_0000_88B2_C3D4);
    chk("R5 R6 store-right be", {56'd0, store_be}, 64'h08);

    apply(3'b111, 3'd7, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1122_3344_5566_7788);
    chk("R7 store-right dword full", store_data, 64'h1122_3344_5566_7788);
    chk("R7 store-right dword be", {56'd0, store_be}, 64'hFF);

    // R9: reset mid-run clears outputs
    apply(3'b000, 3'd0, 1'b1, 64'h0000_0000_1234_5678, 64'd0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 mid reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R9 mid reset load_result", load_result, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule